// File: doc/BRIEF.md
# Inbound Address Window Decoder

This block holds a small bank of programmable inbound windows that translate 32-bit memory addresses arriving from a PCIe link into an internal target. Each window has three registers on a simple register bus. The first is a control word with a size mask at 64 KB granularity, an attribute byte, a target nibble and an enable. The second is a base and the third is a remap value. Both keep only their upper sixteen bits. The block does not forward any transaction. It only answers lookups.

A lookup presents an address with a valid strobe. One cycle later the block returns whether any window matched, which window matched, and that window's target, attribute and translated address. When several windows overlap, the lowest-numbered one wins. A helper register takes the total memory size behind the link and rounds it up to a power of two. The rounded size is published as a ready-made BAR size control word.

Top module: `inwin_decode`

## Requirements
- R1: After reset every window register reads zero, the size register reads zero, `bar_ctrl_o` is zero, and lookups miss.
- R2: Register map. Window n sits at byte offset n*16: +0x0 is control, +0x4 is base, +0x8 is remap, and +0xC reads zero. Control keeps bits 31:16 (size mask), 15:8 (attribute), 7:4 (target) and 0 (enable), and every other bit reads zero. Base and remap keep bits 31:16, and their bits 15:0 read zero. Address bits 1:0 are ignored.
- R3: Window n hits when its enable is 1 and `lkp_addr_i[31:16] & ~mask` equals the window's stored base bits 31:16.
- R4: `rsp_vld_o` is high exactly in the cycle after `lkp_vld_i` is high. The lookup is decided on the register contents from before that clock edge, so a write in the same cycle does not affect it.
- R5: When more than one window hits, the response reports the lowest-numbered window and that window's fields.
- R6: On a hit, `rsp_addr_o[15:0]` equals the lookup address bits 15:0. In bits 31:16, each bit set in the mask comes from the lookup address and each clear bit comes from the remap register.
- R7: On a miss, `rsp_hit_o`, `rsp_win_o`, `rsp_tgt_o`, `rsp_attr_o` and `rsp_addr_o` are all zero.
- R8: A window with enable 0 never hits, even when its base matches.
- R9: Offset NWIN*16 (0x60 by default) takes a total size in bytes. It reads back that size rounded up to the next power of two, and the size is left unchanged when it is already a power of two. A total above 2^31 rounds to 2^32, which reads as 0.
- R10: `bar_ctrl_o` is zero when the stored total is zero. Otherwise bits 31:16 hold bits 31:16 of (rounded − 1), bit 0 is 1, and bits 15:1 are zero.
- R11: Writes to +0xC of a window or to offsets above the size register change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from `reg_addr_i` |
| lkp_vld_i | input | 1 | Lookup request strobe |
| lkp_addr_i | input | 32 | Lookup address |
| rsp_vld_o | output | 1 | Lookup response valid |
| rsp_hit_o | output | 1 | A window matched |
| rsp_win_o | output | 3 | Index of the winning window |
| rsp_tgt_o | output | 4 | Target ID of the winning window |
| rsp_attr_o | output | 8 | Attribute of the winning window |
| rsp_addr_o | output | 32 | Translated address |
| bar_ctrl_o | output | 32 | BAR size control word |

## Verification
The checker assumes that `lkp_addr_i` is stable whenever `lkp_vld_i` is high at a clock edge. It also assumes that reset is held for at least one edge before any traffic. The bench meets both by driving every input on the falling edge and holding it through the following rising edge. It asserts reset for several cycles before the first access. Every window base the bench programs is aligned to that window's size, so each hit region has a single, known extent.

// File: rtl/inwin_decode.sv
module inwin_decode #(
  parameter int NWIN = 6,
  parameter int RAW  = 8,
  parameter int WIW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr_i,
  input  logic [RAW-1:0]  reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  input  logic            lkp_vld_i,
  input  logic [31:0]     lkp_addr_i,
  output logic            rsp_vld_o,
  output logic            rsp_hit_o,
  output logic [WIW-1:0]  rsp_win_o,
  output logic [3:0]      rsp_tgt_o,
  output logic [7:0]      rsp_attr_o,
  output logic [31:0]     rsp_addr_o,
  output logic [31:0]     bar_ctrl_o
);
  localparam int IDXW = RAW - 4;

  logic [15:0] msk_q  [NWIN];
  logic [7:0]  attr_q [NWIN];
  logic [3:0]  tgt_q  [NWIN];
  logic        en_q   [NWIN];
  logic [15:0] base_q [NWIN];
  logic [15:0] rmp_q  [NWIN];
  logic [31:0] total_q;

  logic [IDXW-1:0] idx;
  logic [1:0]      sub;
  logic [NWIN-1:0] hit;

  assign idx = reg_addr_i[RAW-1:4];
  assign sub = reg_addr_i[3:2];

  for (genvar n = 0; n < NWIN; n++) begin : g_win
    logic sel;
    assign sel = reg_wr_i && (idx == IDXW'(n));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        msk_q[n]  <= '0;
        attr_q[n] <= '0;
        tgt_q[n]  <= '0;
        en_q[n]   <= 1'b0;
        base_q[n] <= '0;
        rmp_q[n]  <= '0;
      end else if (sel) begin
        case (sub)
          2'd0: begin
            msk_q[n]  <= reg_wdata_i[31:16];
            attr_q[n] <= reg_wdata_i[15:8];
            tgt_q[n]  <= reg_wdata_i[7:4];
            en_q[n]   <= reg_wdata_i[0];
          end
          2'd1: base_q[n] <= reg_wdata_i[31:16];
          2'd2: rmp_q[n]  <= reg_wdata_i[31:16];
          default: ;
        endcase
      end
    end
    assign hit[n] = en_q[n] && ((lkp_addr_i[31:16] & ~msk_q[n]) == base_q[n]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      total_q <= '0;
    else if (reg_wr_i && idx == IDXW'(NWIN) && sub == 2'd0)
      total_q <= reg_wdata_i;
  end

  logic [31:0] rounded;
  logic [31:0] round_m1;
  logic        is_pow2;
  logic [5:0]  top;

  always_comb begin
    top = '0;
    for (int b = 0; b < 32; b++)
      if (total_q[b]) top = 6'(b);
  end

  assign is_pow2  = (total_q & (total_q - 32'd1)) == '0;
  assign rounded  = is_pow2 ? total_q :
                    (top == 6'd31) ? 32'd0 : (32'd1 << (top + 6'd1));
  assign round_m1 = rounded - 32'd1;
  assign bar_ctrl_o = (total_q == '0) ? '0 : {round_m1[31:16], 15'd0, 1'b1};

  always_comb begin
    reg_rdata_o = '0;
    for (int n = 0; n < NWIN; n++) begin
      if (idx == IDXW'(n)) begin
        case (sub)
          2'd0: reg_rdata_o = {msk_q[n], attr_q[n], tgt_q[n], 3'd0, en_q[n]};
          2'd1: reg_rdata_o = {base_q[n], 16'd0};
          2'd2: reg_rdata_o = {rmp_q[n], 16'd0};
          default: reg_rdata_o = '0;
        endcase
      end
    end
    if (idx == IDXW'(NWIN) && sub == 2'd0) reg_rdata_o = rounded;
  end

  logic [WIW-1:0] win_sel;
  always_comb begin
    win_sel = '0;
    for (int n = NWIN - 1; n >= 0; n--)
      if (hit[n]) win_sel = WIW'(n);
  end

  logic        any_hit;
  logic [15:0] sel_msk;
  logic [15:0] sel_rmp;
  assign any_hit = |hit;
  assign sel_msk = msk_q[win_sel];
  assign sel_rmp = rmp_q[win_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld_o  <= 1'b0;
      rsp_hit_o  <= 1'b0;
      rsp_win_o  <= '0;
      rsp_tgt_o  <= '0;
      rsp_attr_o <= '0;
      rsp_addr_o <= '0;
    end else begin
      rsp_vld_o <= lkp_vld_i;
      if (lkp_vld_i && any_hit) begin
        rsp_hit_o  <= 1'b1;
        rsp_win_o  <= win_sel;
        rsp_tgt_o  <= tgt_q[win_sel];
        rsp_attr_o <= attr_q[win_sel];
        rsp_addr_o <= {(lkp_addr_i[31:16] & sel_msk) | (sel_rmp & ~sel_msk),
                       lkp_addr_i[15:0]};
      end else if (lkp_vld_i) begin
        rsp_hit_o  <= 1'b0;
        rsp_win_o  <= '0;
        rsp_tgt_o  <= '0;
        rsp_attr_o <= '0;
        rsp_addr_o <= '0;
      end
    end
  end
endmodule

// File: rtl/inwin_decode_chk.sv
module inwin_decode_chk #(
  parameter int NWIN = 6,
  parameter int WIW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           lkp_vld_i,
  input logic [31:0]    lkp_addr_i,
  input logic           rsp_vld_o,
  input logic           rsp_hit_o,
  input logic [WIW-1:0] rsp_win_o,
  input logic [3:0]     rsp_tgt_o,
  input logic [7:0]     rsp_attr_o,
  input logic [31:0]    rsp_addr_o,
  input logic [31:0]    bar_ctrl_o
);
  // R4
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_vld_i |=> rsp_vld_o);
  // R4
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_vld_i |=> !rsp_vld_o);
  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld_o && !rsp_hit_o) |->
      (rsp_win_o == '0 && rsp_tgt_o == '0 && rsp_attr_o == '0 && rsp_addr_o == '0));
  // R6
  offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_vld_i ##1 rsp_hit_o |-> rsp_addr_o[15:0] == $past(lkp_addr_i[15:0]));
  // R5
  win_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit_o |-> int'(rsp_win_o) < NWIN);
  // R10
  bar_mask_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_ctrl_o[0] |-> ($onehot({1'b0, bar_ctrl_o[31:16]} + 17'd1) && bar_ctrl_o[15:1] == '0));
  // R10
  bar_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bar_ctrl_o[0] |-> bar_ctrl_o == '0);
endmodule

bind inwin_decode inwin_decode_chk #(.NWIN(NWIN), .WIW(WIW)) chk_i (
  .clk(clk), .rst_n(rst_n), .lkp_vld_i(lkp_vld_i), .lkp_addr_i(lkp_addr_i),
  .rsp_vld_o(rsp_vld_o), .rsp_hit_o(rsp_hit_o), .rsp_win_o(rsp_win_o),
  .rsp_tgt_o(rsp_tgt_o), .rsp_attr_o(rsp_attr_o), .rsp_addr_o(rsp_addr_o),
  .bar_ctrl_o(bar_ctrl_o)
);

// File: tb/inwin_decode_tb.sv
module inwin_decode_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        lkp_vld_i = 1'b0;
  logic [31:0] lkp_addr_i = '0;
  logic        rsp_vld_o, rsp_hit_o;
  logic [2:0]  rsp_win_o;
  logic [3:0]  rsp_tgt_o;
  logic [7:0]  rsp_attr_o;
  logic [31:0] rsp_addr_o, bar_ctrl_o;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inwin_decode dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .lkp_vld_i(lkp_vld_i),
    .lkp_addr_i(lkp_addr_i), .rsp_vld_o(rsp_vld_o), .rsp_hit_o(rsp_hit_o),
    .rsp_win_o(rsp_win_o), .rsp_tgt_o(rsp_tgt_o), .rsp_attr_o(rsp_attr_o),
    .rsp_addr_o(rsp_addr_o), .bar_ctrl_o(bar_ctrl_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr_i = a;
    #1 check(req, reg_rdata_o, exp);
  endtask

  task automatic lkp_chk(input string req, input logic [31:0] a, input logic hit,
                         input logic [2:0] win, input logic [3:0] tgt,
                         input logic [7:0] attr, input logic [31:0] xa);
    @(negedge clk);
    lkp_vld_i = 1'b1; lkp_addr_i = a;
    @(negedge clk);
    lkp_vld_i = 1'b0;
    check({req, " vld"}, 32'(rsp_vld_o), 32'd1);
    check({req, " hit"}, 32'(rsp_hit_o), 32'(hit));
    check({req, " win"}, 32'(rsp_win_o), 32'(win));
    check({req, " tgt"}, 32'(rsp_tgt_o), 32'(tgt));
    check({req, " attr"}, 32'(rsp_attr_o), 32'(attr));
    check({req, " addr"}, rsp_addr_o, xa);
  endtask

  task automatic t_reset;
    for (int n = 0; n < 6; n++) begin
      rd_chk("R1 ctrl", 8'(n*16), 32'h0);
      rd_chk("R1 base", 8'(n*16+4), 32'h0);
      rd_chk("R1 remap", 8'(n*16+8), 32'h0);
    end
    rd_chk("R1 size", 8'h60, 32'h0);
    check("R1 bar_ctrl", bar_ctrl_o, 32'h0);
    check("R1 rsp_vld idle", 32'(rsp_vld_o), 32'h0);
    lkp_chk("R1 lookup", 32'h0000_0000, 1'b0, 3'd0, 4'd0, 8'd0, 32'h0);
  endtask

  task automatic t_readback;
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl bits", 8'h00, 32'hFFFF_FFF1);
    wr(8'h04, 32'h1234_5678);
    rd_chk("R2 base bits", 8'h04, 32'h1234_0000);
    wr(8'h08, 32'hABCD_EF01);
    rd_chk("R2 remap bits", 8'h08, 32'hABCD_0000);
    rd_chk("R2 pad reads zero", 8'h0C, 32'h0);
    rd_chk("R2 low addr bits ignored", 8'h05, 32'h1234_0000);
    wr(8'h00, 32'h0); wr(8'h04, 32'h0); wr(8'h08, 32'h0);
    rd_chk("R2 cleared", 8'h00, 32'h0);
  endtask

  task automatic t_hit;
    wr(8'h20, 32'h000F_A531);
    wr(8'h24, 32'h4010_0000);
    wr(8'h28, 32'h8000_0000);
    lkp_chk("R3 R6 inside", 32'h4012_3456, 1'b1, 3'd2, 4'h3, 8'hA5, 32'h8002_3456);
    lkp_chk("R3 top edge", 32'h401F_FFFF, 1'b1, 3'd2, 4'h3, 8'hA5, 32'h800F_FFFF);
    lkp_chk("R7 above", 32'h4020_0000, 1'b0, 3'd0, 4'd0, 8'd0, 32'h0);
    lkp_chk("R7 below", 32'h400F_FFFF, 1'b0, 3'd0, 4'd0, 8'd0, 32'h0);
  endtask

  task automatic t_priority;
    wr(8'h40, 32'h0000_1171);
    wr(8'h44, 32'h4012_0000);
    wr(8'h48, 32'h0000_0000);
    lkp_chk("R5 low wins", 32'h4012_3456, 1'b1, 3'd2, 4'h3, 8'hA5, 32'h8002_3456);
    wr(8'h20, 32'h0);
    lkp_chk("R5 next wins", 32'h4012_FFFF, 1'b1, 3'd4, 4'h7, 8'h11, 32'h0000_FFFF);
    wr(8'h50, 32'h0000_FFF1);
    wr(8'h54, 32'hFFFF_0000);
    wr(8'h58, 32'h1234_0000);
    lkp_chk("R3 R6 last window", 32'hFFFF_0042, 1'b1, 3'd5, 4'hF, 8'hFF, 32'h1234_0042);
  endtask

  task automatic t_disabled;
    wr(8'h10, 32'h0000_2250);
    wr(8'h14, 32'h7000_0000);
    lkp_chk("R8 disabled", 32'h7000_0010, 1'b0, 3'd0, 4'd0, 8'd0, 32'h0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = 8'h10; reg_wdata_i = 32'h0000_2251;
    lkp_vld_i = 1'b1; lkp_addr_i = 32'h7000_0010;
    @(negedge clk);
    reg_wr_i = 1'b0; lkp_vld_i = 1'b0;
    check("R4 old regs used", 32'(rsp_hit_o), 32'd0);
    check("R4 vld", 32'(rsp_vld_o), 32'd1);
    @(negedge clk);
    check("R4 vld drops", 32'(rsp_vld_o), 32'd0);
    lkp_chk("R4 new regs next", 32'h7000_0010, 1'b1, 3'd1, 4'h5, 8'h22, 32'h0000_0010);
  endtask

  task automatic t_ignored;
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'hF0, 32'hFFFF_FFFF);
    rd_chk("R11 pad", 8'h1C, 32'h0);
    rd_chk("R11 ctrl kept", 8'h10, 32'h0000_2251);
    rd_chk("R11 base kept", 8'h14, 32'h7000_0000);
    rd_chk("R11 remap kept", 8'h18, 32'h0);
    rd_chk("R11 size kept", 8'h60, 32'h0);
    check("R11 bar kept", bar_ctrl_o, 32'h0);
    lkp_chk("R11 lookup kept", 32'h7000_0010, 1'b1, 3'd1, 4'h5, 8'h22, 32'h0000_0010);
  endtask

  task automatic t_bar;
    wr(8'h60, 32'h0300_0000);
    rd_chk("R9 round up", 8'h60, 32'h0400_0000);
    check("R10 ctrl", bar_ctrl_o, 32'h03FF_0001);
    wr(8'h60, 32'h0100_0000);
    rd_chk("R9 pow2 kept", 8'h60, 32'h0100_0000);
    check("R10 ctrl pow2", bar_ctrl_o, 32'h00FF_0001);
    wr(8'h60, 32'h8000_0001);
    rd_chk("R9 wrap", 8'h60, 32'h0);
    check("R10 ctrl full", bar_ctrl_o, 32'hFFFF_0001);
    wr(8'h60, 32'h0000_0300);
    rd_chk("R9 small", 8'h60, 32'h0000_0400);
    check("R10 ctrl small", bar_ctrl_o, 32'h0000_0001);
    wr(8'h60, 32'h0);
    check("R10 ctrl off", bar_ctrl_o, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_hit();
    t_priority();
    t_disabled();
    t_same_cycle();
    t_ignored();
    t_bar();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule